// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block turns single-word read and write requests into the strobe sequence for a DRAM with a multiplexed address bus and active-low row strobe, column strobe and write-enable pins. Each request address is split into a row part and a column part. The row goes out on the shared address bus while the row strobe falls, and the column goes out while the column strobe is low. Once a row has been opened, the controller keeps its row strobe asserted between requests. A later request to the same row therefore needs only a new column cycle. A request to another row first closes the open row for the precharge time.

A free-running timer raises a refresh request at a fixed interval. The refresh is served only while no access is in progress. If a row is open, the refresh closes it first. It then uses column-strobe-before-row-strobe sequencing, so no refresh address is needed. Every delay is a parameter counted in clock cycles. The defaults suit a 10 ns clock: 7 cycles from row to column, 3 cycles of column access and 4 cycles of precharge.

Top module: `pgdram_ctrl`

## Requirements
- R1: The upper ROW_W bits of `req_addr` are the row and the lower COL_W bits are the column. The row is driven on `dram_addr` while `dram_ras_n` is low outside a column phase. The column is driven, zero-extended, while `dram_cas_n` is low. Data written at an address is read back from the same address.
- R2: After reset no row is open. `req_ready` is 1, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, and `rsp_valid` and `dram_dq_oe` are 0. An access with no open row performs one row activation and completes T_RCD+T_CAS cycles after the accepting edge.
- R3: An access to the open row does no precharge and no activation. It completes T_CAS cycles after the accepting edge.
- R4: An access to a row other than the open one raises `dram_ras_n` for at least T_RP cycles and then activates the new row. It completes T_RP+T_RCD+T_CAS cycles after the accepting edge, with exactly one precharge.
- R5: At least T_RCD cycles pass between the fall of `dram_ras_n` and the fall of `dram_cas_n` for a column access.
- R6: A write drives `dram_we_n` low and `dram_dq_oe` high only while both strobes are low, with `dram_dq_out` carrying the request data.
- R7: A read ends with `rsp_valid` high for exactly one cycle. `rsp_rdata` then carries `dram_dq_in` as sampled in the last column cycle.
- R8: While a row is open, `dram_ras_n` stays low between requests and the address bus holds the row. Only a row change or a refresh adds an activation.
- R9: A refresh becomes pending every T_REFI cycles and is served only between accesses, with `req_ready` low. `dram_cas_n` falls one cycle before `dram_ras_n`, both stay low for T_RFC cycles, and then both stay high for T_RP cycles. With no row open, successive refreshes begin T_REFI cycles apart. A refresh that falls due during an access does not lengthen that access.
- R10: A refresh precharges an open row first. The access after a refresh performs a full activation.
- R11: `req_ready` is high only when the controller is idle with no refresh pending. It is low whenever `dram_cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | DW | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DW | Data to the memory |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DW | Data from the memory |

## Verification
The hardest situation to reach from the ports is a refresh timer that expires while an access is already under way. The refresh must then wait for the access to finish and must still close the row that the access left open. The stimulus observes the start of each refresh on the strobe pins. It then counts cycles until just before the next expiry and issues a read at that moment. The bench checks that the read keeps its normal latency and that a precharge comes before the deferred refresh. A bench-side memory model, driven only by the strobe pins, classifies each access as closed, hit or miss and counts activations and precharges.

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DW     = 16,
  parameter int T_RCD  = 7,
  parameter int T_CAS  = 3,
  parameter int T_RP   = 4,
  parameter int T_RFC  = 6,
  parameter int T_REFI = 1560
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                     dram_ras_n,
  output logic                     dram_cas_n,
  output logic                     dram_we_n,
  output logic [DW-1:0]            dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DW-1:0]            dram_dq_in
);
  localparam int AW   = ROW_W + COL_W;
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TM1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2  = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(T_REFI + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ACT, S_COL, S_RFC, S_RFR, S_RFP
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DW-1:0]    wd_q;
  logic             row_open;
  logic             in_ref;
  logic             ref_pend;
  logic [RW-1:0]    ref_tmr;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             take;
  logic             cnt_done;

  assign req_row   = req_addr[AW-1:COL_W];
  assign req_col   = req_addr[COL_W-1:0];
  assign req_ready = (st == S_IDLE) && !ref_pend;
  assign take      = req_valid && req_ready;
  assign cnt_done  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_tmr  <= RW'(T_REFI - 1);
      ref_pend <= 1'b0;
    end else begin
      if (ref_tmr == '0) ref_tmr <= RW'(T_REFI - 1);
      else               ref_tmr <= ref_tmr - 1'b1;
      if (ref_tmr == '0)                  ref_pend <= 1'b1;
      else if (st == S_IDLE && ref_pend)  ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      row_open  <= 1'b0;
      in_ref    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!cnt_done) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            in_ref <= 1'b1;
            if (row_open) begin
              st       <= S_PRE;
              cnt      <= CW'(T_RP - 1);
              row_open <= 1'b0;
            end else begin
              st <= S_RFC;
            end
          end else if (take) begin
            in_ref <= 1'b0;
            row_q  <= req_row;
            col_q  <= req_col;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
            if (row_open && req_row == row_q) begin
              st  <= S_COL;
              cnt <= CW'(T_CAS - 1);
            end else if (row_open) begin
              st       <= S_PRE;
              cnt      <= CW'(T_RP - 1);
              row_open <= 1'b0;
            end else begin
              st       <= S_ACT;
              cnt      <= CW'(T_RCD - 1);
              row_open <= 1'b1;
            end
          end
        end
        S_PRE: begin
          if (cnt_done) begin
            if (in_ref) begin
              st <= S_RFC;
            end else begin
              st       <= S_ACT;
              cnt      <= CW'(T_RCD - 1);
              row_open <= 1'b1;
            end
          end
        end
        S_ACT: begin
          if (cnt_done) begin
            st  <= S_COL;
            cnt <= CW'(T_CAS - 1);
          end
        end
        S_COL: begin
          if (cnt_done) begin
            st <= S_IDLE;
            if (!wr_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
          end
        end
        S_RFC: begin
          st  <= S_RFR;
          cnt <= CW'(T_RFC - 1);
        end
        S_RFR: begin
          if (cnt_done) begin
            st  <= S_RFP;
            cnt <= CW'(T_RP - 1);
          end
        end
        S_RFP: begin
          if (cnt_done) begin
            st     <= S_IDLE;
            in_ref <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dram_ras_n  = !((st == S_ACT) || (st == S_COL) || (st == S_RFR) ||
                         (st == S_IDLE && row_open));
  assign dram_cas_n  = !((st == S_COL) || (st == S_RFC) || (st == S_RFR));
  assign dram_we_n   = !((st == S_COL) && wr_q);
  assign dram_dq_oe  = (st == S_COL) && wr_q;
  assign dram_dq_out = wd_q;
  assign dram_addr   = (st == S_COL) ? MA_W'(col_q) : MA_W'(row_q);

endmodule

// File: rtl/pgdram_ctrl_chk.sv
module pgdram_ctrl_chk #(
  parameter int MA_W  = 10,
  parameter int T_RCD = 7,
  parameter int T_RP  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            dram_ras_n,
  input logic            dram_cas_n,
  input logic            dram_we_n,
  input logic            dram_dq_oe,
  input logic [MA_W-1:0] dram_addr
);
  localparam int HW = $clog2(T_RP + 1);
  localparam int LW = $clog2(T_RCD + 1);

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= HW'(T_RP);
      lo_cnt <= '0;
    end else if (dram_ras_n) begin
      lo_cnt <= '0;
      if (hi_cnt != HW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != LW'(T_RCD)) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R6
  we_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_we_n || dram_dq_oe) |-> (!dram_cas_n && !dram_ras_n));

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !req_ready);

  // R8
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && dram_cas_n && $past(!dram_ras_n && dram_cas_n)) |-> $stable(dram_addr));

  // R4
  pre_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= HW'(T_RP)));

  // R5
  rcd_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> (lo_cnt >= LW'(T_RCD)));

endmodule

bind pgdram_ctrl pgdram_ctrl_chk #(.MA_W(MA_W), .T_RCD(T_RCD), .T_RP(T_RP)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
  .dram_dq_oe(dram_dq_oe), .dram_addr(dram_addr)
);

// File: tb/test_pgdram_ctrl.sv
`timescale 1ns/1ps
module test_pgdram_ctrl;
  localparam int ROW_W = 4, COL_W = 4, DW = 16;
  localparam int T_RCD = 7, T_CAS = 3, T_RP = 4, T_RFC = 6, T_REFI = 2000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [15:0] rsp_rdata, dram_dq_out, dram_dq_in;
  logic [3:0] dram_addr;

  pgdram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
                .T_RP(T_RP), .T_RFC(T_RFC), .T_REFI(T_REFI)) i_pgdram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // memory model driven only by the strobe pins
  logic [15:0] mem [256];
  logic [3:0]  m_row = '0;
  logic        ras_q = 1'b1;
  int n_act = 0, n_pre = 0, n_ref = 0, last_ref = 0, prev_ref = 0;
  assign dram_dq_in = mem[{m_row, dram_addr}];

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_q && !dram_ras_n) begin
        if (dram_cas_n) begin
          m_row = dram_addr;
          n_act++;
        end else begin
          n_ref++;
          prev_ref = last_ref;
          last_ref = cyc;
          check("R9 ready low during refresh", {31'd0, req_ready}, 32'd0);
        end
      end
      if (!ras_q && dram_ras_n) n_pre++;
      if (!dram_ras_n && !dram_cas_n && !dram_we_n && dram_dq_oe)
        mem[{m_row, dram_addr}] = dram_dq_out;
      ras_q = dram_ras_n;
    end
  end

  task automatic do_req(input logic wr, input logic [7:0] a, input logic [15:0] d,
                        output int lat, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    lat = 0; rd = '0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (wr ? req_ready : rsp_valid) begin rd = rsp_rdata; break; end
      @(posedge clk);
      lat++;
      if (lat > 200) break;
    end
  endtask

  // {write, addr, data, kind}  kind: 0 no open row, 1 same row, 2 other row
  localparam logic [26:0] VEC [12] = '{
    {1'b1, 8'h35, 16'hA1B2, 2'd0},
    {1'b1, 8'h3A, 16'h1111, 2'd1},
    {1'b0, 8'h35, 16'hA1B2, 2'd1},
    {1'b0, 8'h3A, 16'h1111, 2'd1},
    {1'b1, 8'h70, 16'h2222, 2'd2},
    {1'b0, 8'h35, 16'hA1B2, 2'd2},
    {1'b0, 8'h70, 16'h2222, 2'd2},
    {1'b1, 8'h7F, 16'h3333, 2'd1},
    {1'b1, 8'h70, 16'h4444, 2'd1},
    {1'b0, 8'h70, 16'h4444, 2'd1},
    {1'b0, 8'h7F, 16'h3333, 2'd1},
    {1'b0, 8'h3A, 16'h1111, 2'd2}
  };

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat, a0, p0, r0, guard;
    logic [15:0] rd;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R2 ready after reset", {31'd0, req_ready}, 32'd1);
    check("R2 ras_n after reset", {31'd0, dram_ras_n}, 32'd1);
    check("R2 cas_n after reset", {31'd0, dram_cas_n}, 32'd1);
    check("R2 we_n after reset", {31'd0, dram_we_n}, 32'd1);
    check("R2 rsp/oe after reset", {30'd0, rsp_valid, dram_dq_oe}, 32'd0);

    for (int i = 0; i < 12; i++) begin
      logic wr; logic [7:0] a; logic [15:0] d; logic [1:0] k; int exp_lat;
      {wr, a, d, k} = VEC[i];
      exp_lat = (k == 2'd0) ? T_RCD + T_CAS : (k == 2'd1) ? T_CAS : T_RP + T_RCD + T_CAS;
      a0 = n_act; p0 = n_pre;
      do_req(wr, a, d, lat, rd);
      check(k == 2'd0 ? "R2 closed latency" : k == 2'd1 ? "R3 hit latency" : "R4 miss latency",
            lat, exp_lat);
      check("R8 activations", n_act - a0, (k == 2'd1) ? 0 : 1);
      check("R4 precharges", n_pre - p0, (k == 2'd2) ? 1 : 0);
      if (!wr) begin
        check("R1 R6 R7 read data", {16'd0, rd}, {16'd0, d});
        @(negedge clk);
        check("R7 single pulse", {31'd0, rsp_valid}, 32'd0);
      end else begin
        check("R8 ras held after write", {31'd0, dram_ras_n}, 32'd0);
      end
    end

    // refresh closes the open row (row 3)
    r0 = n_ref; p0 = n_pre; guard = 0;
    while (n_ref == r0 && guard < 5000) begin @(negedge clk); guard++; end
    check("R10 precharge before refresh", n_pre - p0, 1);
    do_req(1'b0, 8'h3A, 16'h0, lat, rd);
    check("R10 full activation after refresh", lat, T_RCD + T_CAS);
    check("R10 data after refresh", {16'd0, rd}, 32'h1111);

    // spacing between refreshes with no open row
    r0 = n_ref; guard = 0;
    while (n_ref < r0 + 3 && guard < 9000) begin @(negedge clk); guard++; end
    check("R9 refresh interval", last_ref - prev_ref, T_REFI);

    // timer expires while an access is in progress
    guard = 0;
    while (cyc < last_ref + T_REFI - 7 && guard < 3000) begin @(negedge clk); guard++; end
    r0 = n_ref; p0 = n_pre;
    do_req(1'b0, 8'h7F, 16'h0, lat, rd);
    check("R9 access not lengthened", lat, T_RCD + T_CAS);
    check("R9 data", {16'd0, rd}, 32'h3333);
    guard = 0;
    while (n_ref == r0 && guard < 100) begin @(negedge clk); guard++; end
    check("R9 deferred refresh occurs", n_ref - r0, 1);
    check("R10 deferred refresh precharges", n_pre - p0, 1);

    finish_run();
  end
endmodule